// File: doc/BRIEF.md
# Frame-Locked Raster Timing Generator

This block produces the horizontal and vertical timing of a 640x480 raster from its own local pixel clock. It also produces the read address into a frame store that holds a slower 15 kHz source. The output timing runs freely. It is pulled into step with the incoming source only once per incoming frame, using the incoming vertical sync. Any rate difference between the two clocks therefore shows up as a longer or shorter vertical blanking interval. It never shows up as a line shifted against its neighbours, which is what jitter from per-line re-timing would look like.

The incoming vertical sync is asynchronous. It is synchronised, and each of its rising edges is recorded as a pending request. The request is honoured at the end of the first output line that lies in vertical blanking. At that point the counters jump to column 0 of a fixed alignment line, and the request clears. Each stored row is shown twice, so a store of 204 rows fills 408 output lines. The lines below that show black.

The read address is issued one clock before the sync and active outputs that belong to it. The store's one-cycle read latency then lines up the pixel data with the timing outputs.

Top module: `vga_framelock_timing`

## Requirements
- R1: The column count runs 0 to H_TOTAL-1 (default 800) and then returns to 0, so each line lasts H_TOTAL clocks.
- R2: The line count advances once per line, runs 0 to V_TOTAL-1 (default 525) and then returns to 0.
- R3: `video_active` is high only for columns below H_ACTIVE (640) on lines below V_ACTIVE (480).
- R4: `hsync_n` is low (active-low) exactly for columns HS_START..HS_END inclusive (655..752) and high elsewhere.
- R5: `vsync_n` is low (active-low) exactly for lines VS_START..VS_END inclusive (490..492) and high elsewhere.
- R6: A rising edge on `vin_vsync` reaches the realignment logic through a two-stage synchroniser and is held as a pending request. The request takes effect at the end of the first line whose number is V_ACTIVE or more. The next clock then shows column 0 of line ALIGN_LINE (default 493), and the request clears. Several edges that arrive before the request takes effect cause one realignment.
- R7: Without a request, the counters run freely and are never disturbed. A pending request never alters timing during an active line (line below V_ACTIVE).
- R8: For an active pixel at column c of line n, `rd_addr` = (n/2)*H_ACTIVE + c. It appears one clock before the `hsync_n`, `vsync_n` and `video_active` values of the same pixel.
- R9: `rd_valid` is high only for active pixels on lines below 2*STORED_ROWS (408 by default). On other pixels, including lines 408..479, `rd_valid` is low and `rd_addr` is 0.
- R10: While `rst_n` is low at a clock edge, both counters go to zero and any pending request is dropped. After that edge, `hsync_n` and `vsync_n` are high, `video_active` and `rd_valid` are low, and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vin_vsync | input | 1 | Incoming vertical sync, asynchronous, high-going pulse |
| hsync_n | output | 1 | Output horizontal sync, active low |
| vsync_n | output | 1 | Output vertical sync, active low |
| video_active | output | 1 | High inside the visible 640x480 window |
| rd_valid | output | 1 | High when `rd_addr` selects a stored pixel |
| rd_addr | output | ADDR_W | Frame store read address, row*H_ACTIVE + column |

## Verification
A wrong column or line count shows up at the ports at once. The sync pulses and the active window move by the error, and this is visible within the same line or frame. Mis-handled realignment appears at the end of the next output frame. It can show as a vertical sync pulse that should have been skipped, a visible period starting at the wrong clock, or a jump made while the picture is being drawn, and the bench measures these as exact clock counts. A request that survives reset, or that is applied more than once, moves the next vertical sync by whole lines and is caught at the first pulse after it.

// File: rtl/vft_pkg.sv
// Package: shared types for the frame-locked raster timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package vft_pkg;

    // Timing flags that travel through the output pipeline together
    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic act;
    } vft_flags_t;

    localparam vft_flags_t VFT_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, act: 1'b0};

endpackage

// File: rtl/vft_vsync_edge.sv
// Module: brings the asynchronous input vertical sync into the clock
// domain through SYNC_STAGES flops, then flags each rising edge for one clock.
// Assumes: input pulses are wider than one clock period.
module vft_vsync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic rise
);

    logic [SYNC_STAGES:0] shreg;

    // Shift the input through the synchroniser plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SYNC_STAGES-1:0], vin};
    end

    // Edge flag: newest synchronised sample high, previous one low
    always_comb rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

    // A rise lasts exactly one clock (R6)
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/vft_realign.sv
// Module: keeps the pending realignment request, and releases it at the
// end of the first line that lies in vertical blanking.
// Assumes: hcnt/vcnt come from vft_counters in the same clock domain.
module vft_realign #(
    parameter int H_TOTAL  = 800,
    parameter int V_ACTIVE = 480,
    parameter int HC_W     = 10,
    parameter int VC_W     = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic [HC_W-1:0] hcnt,
    input  logic [VC_W-1:0] vcnt,
    output logic            load,
    output logic            pending
);

    localparam logic [HC_W-1:0] H_LAST  = HC_W'(H_TOTAL - 1);
    localparam logic [VC_W-1:0] V_BLANK = VC_W'(V_ACTIVE);

    // Release the request only at a line end inside vertical blanking
    always_comb load = pending && (vcnt >= V_BLANK) && (hcnt == H_LAST);

    // Hold the request until it is used; a new edge always re-arms it
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= rise | (pending & ~load);
    end

    // A rise always leaves a pending request behind (R6)
    p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pending);

    // A used request is gone unless a fresh edge came in that cycle (R6)
    p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !rise) |=> !pending);

endmodule

// File: rtl/vft_counters.sv
// Module: column and line counters of the output raster. They run
// freely and jump to column 0 of ALIGN_LINE when load is pulsed.
// Assumes: load arrives only at a blanking line end (checked below).
module vft_counters #(
    parameter int H_TOTAL    = 800,
    parameter int V_TOTAL    = 525,
    parameter int V_ACTIVE   = 480,
    parameter int ALIGN_LINE = 493,
    parameter int HC_W       = 10,
    parameter int VC_W       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    output logic [HC_W-1:0] hcnt,
    output logic [VC_W-1:0] vcnt
);

    localparam logic [HC_W-1:0] H_LAST  = HC_W'(H_TOTAL - 1);
    localparam logic [VC_W-1:0] V_LAST  = VC_W'(V_TOTAL - 1);
    localparam logic [VC_W-1:0] V_ALIGN = VC_W'(ALIGN_LINE);
    localparam logic [VC_W-1:0] V_BLANK = VC_W'(V_ACTIVE);

    logic line_end;
    always_comb line_end = (hcnt == H_LAST);

    // Column counter: wrap at line end, restart on realignment
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt <= '0;
        else if (load)     hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else               hcnt <= hcnt + 1'b1;
    end

    // Line counter: step at line end, wrap at frame end, jump on realignment
    always_ff @(posedge clk) begin
        if (!rst_n)            vcnt <= '0;
        else if (load)         vcnt <= V_ALIGN;
        else if (line_end) begin
            if (vcnt == V_LAST) vcnt <= '0;
            else                vcnt <= vcnt + 1'b1;
        end
    end

    // Columns advance by one inside a line (R1)
    p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && hcnt != H_LAST) |=> hcnt == $past(hcnt) + 1'b1);

    // The line changes only at a line end (R2)
    p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && hcnt != H_LAST) |=> $stable(vcnt));

    // The frame wraps to line 0 after its last line (R2)
    p_vwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && hcnt == H_LAST && vcnt == V_LAST) |=> (vcnt == '0 && hcnt == '0));

    // Realignment comes only at a blanking line end (R6, R7)
    p_load_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (vcnt >= V_BLANK && line_end));

    // Realignment lands on the alignment line at column 0 (R6)
    p_load_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hcnt == '0 && vcnt == V_ALIGN));

    // Active lines are never disturbed (R7)
    p_active_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vcnt < V_BLANK) |-> !load);

endmodule

// File: rtl/vft_out_stage.sv
// Module: decodes the counters into sync and window flags and the
// line-doubled read address. The address is registered once; the flags
// are registered twice, so they line up with data read one cycle later.
// Assumes: the frame store has one clock of read latency.
module vft_out_stage
    import vft_pkg::*;
#(
    parameter int H_ACTIVE    = 640,
    parameter int HS_START    = 655,
    parameter int HS_END      = 752,
    parameter int V_ACTIVE    = 480,
    parameter int VS_START    = 490,
    parameter int VS_END      = 492,
    parameter int STORED_ROWS = 204,
    parameter int HC_W        = 10,
    parameter int VC_W        = 10,
    parameter int ADDR_W      = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HC_W-1:0]   hcnt,
    input  logic [VC_W-1:0]   vcnt,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              video_active,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int SHOWN_INT = (2 * STORED_ROWS < V_ACTIVE) ? 2 * STORED_ROWS : V_ACTIVE;
    localparam logic [HC_W-1:0]   H_VIS    = HC_W'(H_ACTIVE);
    localparam logic [HC_W-1:0]   HS_FIRST = HC_W'(HS_START);
    localparam logic [HC_W-1:0]   HS_LAST  = HC_W'(HS_END);
    localparam logic [VC_W-1:0]   V_VIS    = VC_W'(V_ACTIVE);
    localparam logic [VC_W-1:0]   VS_FIRST = VC_W'(VS_START);
    localparam logic [VC_W-1:0]   VS_LAST  = VC_W'(VS_END);
    localparam logic [VC_W-1:0]   V_SHOWN  = VC_W'(SHOWN_INT);
    localparam logic [ADDR_W-1:0] LINE_LEN = ADDR_W'(H_ACTIVE);

    vft_flags_t flags_now, flags_s1, flags_s2;
    logic       fetch_now;
    logic [VC_W-1:0]   row;
    logic [ADDR_W-1:0] addr_now;

    // Decode the current counter position into timing flags
    always_comb begin
        flags_now.hs_n = !((hcnt >= HS_FIRST) && (hcnt <= HS_LAST));
        flags_now.vs_n = !((vcnt >= VS_FIRST) && (vcnt <= VS_LAST));
        flags_now.act  = (hcnt < H_VIS) && (vcnt < V_VIS);
    end

    // Line doubling: each stored row serves two output lines
    always_comb begin
        row       = vcnt >> 1;
        fetch_now = (hcnt < H_VIS) && (vcnt < V_SHOWN);
        addr_now  = fetch_now ? (ADDR_W'(row) * LINE_LEN + ADDR_W'(hcnt)) : '0;
    end

    // First stage: read address and its flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_s1 <= VFT_IDLE;
            rd_valid <= 1'b0;
            rd_addr  <= '0;
        end else begin
            flags_s1 <= flags_now;
            rd_valid <= fetch_now;
            rd_addr  <= addr_now;
        end
    end

    // Second stage: delay the flags to match the store's read latency
    always_ff @(posedge clk) begin
        if (!rst_n) flags_s2 <= VFT_IDLE;
        else        flags_s2 <= flags_s1;
    end

    always_comb begin
        hsync_n      = flags_s2.hs_n;
        vsync_n      = flags_s2.vs_n;
        video_active = flags_s2.act;
    end

    // A fetched pixel is shown as active one clock later (R8, R9)
    p_valid_then_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> video_active);

    // No fetch means a zero address (R9)
    p_addr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_addr == '0);

    // Sync pulses stay outside the visible window (R4)
    p_hs_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !video_active);

    // Vertical sync stays outside the visible window (R5)
    p_vs_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !video_active);

    // Reset leaves every output idle (R10)
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (hsync_n && vsync_n && !video_active && !rd_valid && rd_addr == '0));

endmodule

// File: rtl/vga_framelock_timing.sv
// Module: top of the frame-locked raster timing generator. It runs the
// output raster from the local clock and realigns it to the incoming
// vertical sync at most once per incoming frame, inside vertical blanking.
// Assumes: clk is the output pixel clock; vin_vsync is asynchronous.
module vga_framelock_timing #(
    parameter int H_ACTIVE    = 640,
    parameter int HS_START    = 655,
    parameter int HS_END      = 752,
    parameter int H_TOTAL     = 800,
    parameter int V_ACTIVE    = 480,
    parameter int VS_START    = 490,
    parameter int VS_END      = 492,
    parameter int V_TOTAL     = 525,
    parameter int STORED_ROWS = 204,
    parameter int ALIGN_LINE  = 493,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(STORED_ROWS * H_ACTIVE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vin_vsync,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              video_active,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int HC_W = $clog2(H_TOTAL);
    localparam int VC_W = $clog2(V_TOTAL);

    logic            rise, load, pending;
    logic [HC_W-1:0] hcnt;
    logic [VC_W-1:0] vcnt;

    vft_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .vin(vin_vsync), .rise(rise)
    );

    vft_realign #(
        .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .HC_W(HC_W), .VC_W(VC_W)
    ) u_realign (
        .clk(clk), .rst_n(rst_n), .rise(rise), .hcnt(hcnt), .vcnt(vcnt),
        .load(load), .pending(pending)
    );

    vft_counters #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .V_ACTIVE(V_ACTIVE),
        .ALIGN_LINE(ALIGN_LINE), .HC_W(HC_W), .VC_W(VC_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .hcnt(hcnt), .vcnt(vcnt)
    );

    vft_out_stage #(
        .H_ACTIVE(H_ACTIVE), .HS_START(HS_START), .HS_END(HS_END),
        .V_ACTIVE(V_ACTIVE), .VS_START(VS_START), .VS_END(VS_END),
        .STORED_ROWS(STORED_ROWS), .HC_W(HC_W), .VC_W(VC_W), .ADDR_W(ADDR_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .video_active(video_active),
        .rd_valid(rd_valid), .rd_addr(rd_addr)
    );

    // A pending request never survives reset (R10)
    p_reset_drops_pend_r10: assert property (@(posedge clk)
        !rst_n |=> !pending);

endmodule

// File: tb/vga_framelock_timing_bench.sv
// Bench: small raster (20 clocks x 15 lines, 12x10 visible, 4 stored rows,
// alignment line 13). A vector table covers free-running timing; directed
// tests then cover realignment, request merging and reset.
module vga_framelock_timing_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vin_vsync = 1'b0;
    logic       hsync_n, vsync_n, video_active, rd_valid;
    logic [5:0] rd_addr;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;

    always #4 clk = ~clk;

    vga_framelock_timing #(
        .H_ACTIVE(12), .HS_START(14), .HS_END(16), .H_TOTAL(20),
        .V_ACTIVE(10), .VS_START(11), .VS_END(12), .V_TOTAL(15),
        .STORED_ROWS(4), .ALIGN_LINE(13), .SYNC_STAGES(2)
    ) u_vga_framelock_timing (
        .clk(clk), .rst_n(rst_n), .vin_vsync(vin_vsync),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .video_active(video_active),
        .rd_valid(rd_valid), .rd_addr(rd_addr)
    );

    // Edges counted since reset release
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic go_to(input int t);
        while (edges < t) @(negedge clk);
    endtask

    task automatic chk_idle(input string req);
        chk(req, "hsync_n idle", int'(hsync_n), 1);
        chk(req, "vsync_n idle", int'(vsync_n), 1);
        chk(req, "video_active idle", int'(video_active), 0);
        chk(req, "rd_valid idle", int'(rd_valid), 0);
        chk(req, "rd_addr idle", int'(rd_addr), 0);
    endtask

    typedef struct packed {
        int         t;
        logic       hs;
        logic       vs;
        logic       act;
        logic       val;
        logic [7:0] addr;
    } vec_t;

    // Outputs after edge t: flags of position t-2, address of position t-1
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{t:1,   hs:1'b1, vs:1'b1, act:1'b0, val:1'b1, addr:8'd0},
        '{t:2,   hs:1'b1, vs:1'b1, act:1'b1, val:1'b1, addr:8'd1},
        '{t:13,  hs:1'b1, vs:1'b1, act:1'b1, val:1'b0, addr:8'd0},
        '{t:14,  hs:1'b1, vs:1'b1, act:1'b0, val:1'b0, addr:8'd0},
        '{t:16,  hs:1'b0, vs:1'b1, act:1'b0, val:1'b0, addr:8'd0},
        '{t:18,  hs:1'b0, vs:1'b1, act:1'b0, val:1'b0, addr:8'd0},
        '{t:19,  hs:1'b1, vs:1'b1, act:1'b0, val:1'b0, addr:8'd0},
        '{t:25,  hs:1'b1, vs:1'b1, act:1'b1, val:1'b1, addr:8'd4},
        '{t:45,  hs:1'b1, vs:1'b1, act:1'b1, val:1'b1, addr:8'd16},
        '{t:145, hs:1'b1, vs:1'b1, act:1'b1, val:1'b1, addr:8'd40},
        '{t:165, hs:1'b1, vs:1'b1, act:1'b1, val:1'b0, addr:8'd0},
        '{t:222, hs:1'b1, vs:1'b0, act:1'b0, val:1'b0, addr:8'd0},
        '{t:256, hs:1'b0, vs:1'b0, act:1'b0, val:1'b0, addr:8'd0},
        '{t:262, hs:1'b1, vs:1'b1, act:1'b0, val:1'b0, addr:8'd0},
        '{t:302, hs:1'b1, vs:1'b1, act:1'b1, val:1'b1, addr:8'd1}
    };

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int vs_low_a = 0, hs_low_a = 0;
        int act_rise_a = -1, vs_fall_b = -1, vs_rise_b = -1, act_rise_c = -1;

        // R10: idle outputs while reset is held
        repeat (3) @(negedge clk);
        chk_idle("R10");
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R8 R9: free-running vector table (t=302 shows the R1/R2 wrap)
        for (int i = 0; i < NV; i++) begin
            go_to(VECS[i].t);
            chk("R4", $sformatf("hsync_n at t=%0d", VECS[i].t), int'(hsync_n), int'(VECS[i].hs));
            chk("R5", $sformatf("vsync_n at t=%0d", VECS[i].t), int'(vsync_n), int'(VECS[i].vs));
            chk("R3", $sformatf("video_active at t=%0d", VECS[i].t), int'(video_active), int'(VECS[i].act));
            chk("R9", $sformatf("rd_valid at t=%0d", VECS[i].t), int'(rd_valid), int'(VECS[i].val));
            chk("R8", $sformatf("rd_addr at t=%0d", VECS[i].t), int'(rd_addr), int'(VECS[i].addr));
        end

        // R6 R7: input edge mid-frame, then two edges in one frame (merged)
        for (int e = 340; e <= 1130; e++) begin
            go_to(e);
            if (e >= 351 && e <= 600 && !vsync_n) vs_low_a++;
            if (e >= 521 && e <= 560 && !hsync_n) hs_low_a++;
            if (e >= 521 && act_rise_a < 0 && video_active) act_rise_a = e;
            if (e >= 601 && vs_fall_b < 0 && !vsync_n) vs_fall_b = e;
            if (vs_fall_b > 0 && vs_rise_b < 0 && vsync_n) vs_rise_b = e;
            if (e >= 1090 && act_rise_c < 0 && video_active) act_rise_c = e;
            vin_vsync = ((e >= 350 && e <= 355) || (e >= 870 && e <= 873) ||
                         (e >= 900 && e <= 903)) ? 1'b1 : 1'b0;
        end
        chk("R6", "vsync lows in realigned frame", vs_low_a, 0);
        chk("R7", "hsync lows across the jump", hs_low_a, 6);
        chk("R6", "first active after realignment", act_rise_a, 562);
        chk("R7", "free-run vsync fall after realignment", vs_fall_b, 782);
        chk("R5", "vsync pulse end", vs_rise_b, 822);
        chk("R6", "single realignment for two edges", act_rise_c, 1122);

        // R10: pending request dropped by reset; counters restart from zero
        go_to(1140);
        vin_vsync = 1'b1;
        go_to(1144);
        vin_vsync = 1'b0;
        go_to(1150);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R10");
        rst_n = 1'b1;
        go_to(2);
        chk("R10", "restart active", int'(video_active), 1);
        chk("R10", "restart address", int'(rd_addr), 1);
        go_to(222);
        chk("R10", "vsync after reset not skipped", int'(vsync_n), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule